// File: doc/BRIEF.md
# Display Active State Sequencer

This block decides, line by line, whether the display fetch and render engine runs. It keeps a three-state record: idle, preparing and running. The states move on a line-advance strobe from an external vertical counter. The block also reacts to writes of the video mode select bits. From the mode, region and height selects it derives three values for the rest of the display pipeline: the line where the idle period starts, and the heights of the top and bottom borders.

The extended mode has a hidden preparation line at count 0x1FF, one line before the visible frame. The legacy mode starts running directly at count 0. If neither mode is selected, the block stays idle. If a mode is selected again part-way through a frame, the sequencer resumes at once. Software can use this to stretch the vertical border by switching the mode off and back on.

Top module: `disp_seq_top`

## Requirements
- R1: After reset the state is idle (`seqState` = 0). `isActive` is 0 and `vblankFlag` is 1. State encoding: idle = 0, preparing = 1, running = 2.
- R2: When the state is running, a line advance to a count equal to `inactStart` moves the state to idle. A line advance to any other count leaves it running.
- R3: In the extended mode, the idle state moves to preparing on a line advance to count 0x1FF. The next line advance moves preparing to running.
- R4: In the legacy mode, the idle state moves straight to running on a line advance to count 0. A line advance to count 0x1FF has no effect.
- R5: While neither mode select is set, the state becomes idle on the next clock and stays idle for every count, including 0x1FF and 0.
- R6: A mode write that leaves a mode selected while the state is idle moves the state to running if `vCount` < `inactStart`. Otherwise, in the extended mode with `vCount` = 0x1FF, it moves the state to preparing. In all other cases the state stays idle. A mode write while the state is preparing or running does not change the state.
- R7: `isActive` is 1 exactly when the state is not idle and `dispEn` is 1. `vblankFlag` is the inverse of `isActive`.
- R8: In the extended mode, `inactStart`, `borderTop` and `borderBot` are set as follows:
  - 30 rows at 60 Hz: 0xF0, 1 and 3.
  - 30 rows at 50 Hz: 0xF0, 24 and 24.
  - 28 rows at 60 Hz: 0xE0, 11 and 8.
  - 28 rows at 50 Hz: 0xE0, 38 and 32.
  
  These outputs follow the select inputs in the same cycle.
- R9: Outside the extended mode, `inactStart` is 0xC0 and the height select is ignored. The borders are 27 and 24 at 60 Hz, and 54 and 48 at 50 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vCount | input | 9 | Current vertical line count |
| lineAdv | input | 1 | Strobe: `vCount` has just advanced to a new line |
| modeWrite | input | 1 | Strobe: the mode selects have just been written |
| dispEn | input | 1 | Display enable |
| extMode | input | 1 | Extended video mode select |
| legacyMode | input | 1 | Legacy video mode select |
| pal50 | input | 1 | 1 = 50 Hz region, 0 = 60 Hz |
| tallMode | input | 1 | 1 = 30-row height, 0 = 28 rows |
| seqState | output | 2 | Sequencer state (0 idle, 1 preparing, 2 running) |
| isActive | output | 1 | Render engine runs this line |
| vblankFlag | output | 1 | Vertical-blank status bit |
| inactStart | output | 9 | First line of the idle period |
| borderTop | output | 6 | Top border height in lines |
| borderBot | output | 6 | Bottom border height in lines |

## Verification
The hardest case to reach is the mid-frame recovery. It requires the block to be forced idle by deselecting both modes and then given a mode write at a chosen count. The bench disables the modes, moves the counter to a line inside the active area or to the hidden line 0x1FF, and then reselects the extended mode. It checks that the state becomes running in the first case and preparing in the second. It also applies a mode write while the state is running, to show that the write does not disturb it.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;
  parameter int VW = 9;
  parameter int BW = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  // comparison strobes passed from the geometry datapath to the FSM
  typedef struct packed {
    logic noMode;
    logic extSel;
    logic hitInact;
    logic hitActive;
    logic belowInact;
    logic atHidden;
  } cmpFlags_t;

  localparam logic [VW-1:0] EXT_TALL_START  = 9'h0F0;
  localparam logic [VW-1:0] EXT_SHORT_START = 9'h0E0;
  localparam logic [VW-1:0] LEG_START       = 9'h0C0;
  localparam logic [VW-1:0] HIDDEN_LINE     = 9'h1FF;
endpackage

// File: rtl/disp_seq_geom.sv
module disp_seq_geom
  import disp_seq_pkg::*;
#(
  parameter int VWID = VW,
  parameter int BWID = BW
) (
  input  logic [VWID-1:0] vCount,
  input  logic            extMode,
  input  logic            legacyMode,
  input  logic            pal50,
  input  logic            tallMode,
  output logic [VWID-1:0] inactStart,
  output logic [BWID-1:0] borderTop,
  output logic [BWID-1:0] borderBot,
  output cmpFlags_t       flags
);
  // one extra bit so that the "no mode" target line is unreachable
  localparam int AW = VWID + 1;
  logic [AW-1:0] activeLine;

  always_comb begin
    if (extMode) begin
      inactStart = tallMode ? EXT_TALL_START : EXT_SHORT_START;
      case ({tallMode, pal50})
        2'b10:   begin borderTop = BWID'(1);  borderBot = BWID'(3);  end
        2'b11:   begin borderTop = BWID'(24); borderBot = BWID'(24); end
        2'b01:   begin borderTop = BWID'(38); borderBot = BWID'(32); end
        default: begin borderTop = BWID'(11); borderBot = BWID'(8);  end
      endcase
      activeLine = {1'b0, HIDDEN_LINE};
    end else begin
      inactStart = LEG_START;
      borderTop  = pal50 ? BWID'(54) : BWID'(27);
      borderBot  = pal50 ? BWID'(48) : BWID'(24);
      activeLine = legacyMode ? '0 : {1'b1, {VWID{1'b0}}};
    end
  end

  always_comb begin
    flags.noMode     = !extMode && !legacyMode;
    flags.extSel     = extMode;
    flags.hitInact   = (vCount == inactStart);
    flags.hitActive  = ({1'b0, vCount} == activeLine);
    flags.belowInact = (vCount < inactStart);
    flags.atHidden   = (vCount == HIDDEN_LINE);
  end
endmodule

// File: rtl/disp_seq_fsm.sv
module disp_seq_fsm
  import disp_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lineAdv,
  input  logic      modeWrite,
  input  cmpFlags_t flags,
  output seqState_t state
);
  seqState_t nextState;

  always_comb begin
    nextState = state;
    if (flags.noMode) begin
      nextState = ST_IDLE;
    end else if (modeWrite && state == ST_IDLE) begin
      // mid-frame recovery after a forced idle
      if (flags.belowInact)                   nextState = ST_RUN;
      else if (flags.extSel && flags.atHidden) nextState = ST_PREP;
    end else if (lineAdv) begin
      case (state)
        ST_PREP: nextState = ST_RUN;
        ST_RUN:  if (flags.hitInact) nextState = ST_IDLE;
        default: if (flags.hitActive) nextState = flags.extSel ? ST_PREP : ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end
endmodule

// File: rtl/disp_seq_top.sv
module disp_seq_top
  import disp_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vCount,
  input  logic          lineAdv,
  input  logic          modeWrite,
  input  logic          dispEn,
  input  logic          extMode,
  input  logic          legacyMode,
  input  logic          pal50,
  input  logic          tallMode,
  output logic [1:0]    seqState,
  output logic          isActive,
  output logic          vblankFlag,
  output logic [VW-1:0] inactStart,
  output logic [BW-1:0] borderTop,
  output logic [BW-1:0] borderBot
);
  cmpFlags_t flags;
  seqState_t state;

  disp_seq_geom #(.VWID(VW), .BWID(BW)) geom_i (
    .vCount(vCount), .extMode(extMode), .legacyMode(legacyMode),
    .pal50(pal50), .tallMode(tallMode), .inactStart(inactStart),
    .borderTop(borderTop), .borderBot(borderBot), .flags(flags)
  );

  disp_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .lineAdv(lineAdv), .modeWrite(modeWrite),
    .flags(flags), .state(state)
  );

  assign seqState   = state;
  assign isActive   = (state != ST_IDLE) && dispEn;
  assign vblankFlag = !isActive;
endmodule

// File: rtl/disp_seq_chk.sv
module disp_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] vCount,
  input logic       lineAdv,
  input logic       modeWrite,
  input logic       dispEn,
  input logic       extMode,
  input logic       legacyMode,
  input logic       pal50,
  input logic       tallMode,
  input logic [1:0] seqState,
  input logic       isActive,
  input logic [8:0] inactStart,
  input logic [5:0] borderTop,
  input logic [5:0] borderBot
);
  logic anyMode;
  assign anyMode = extMode || legacyMode;

  a_r2_run_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (seqState == 2'd2 && lineAdv && !modeWrite && anyMode && vCount == inactStart)
    |=> seqState == 2'd0);

  a_r3_prep_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (seqState == 2'd1 && lineAdv && !modeWrite && anyMode) |=> seqState == 2'd2);

  a_r3_prep_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (seqState == 2'd1 && $past(seqState) != 2'd1) |-> $past(seqState) == 2'd0);

  a_r5_no_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyMode) |=> seqState == 2'd0);

  a_r7_disp_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!dispEn || seqState == 2'd0) |-> !isActive);

  a_r8_short_border: assert property (@(posedge clk) disable iff (!rst_n)
    (extMode && tallMode && !pal50) |-> (inactStart == 9'h0F0 && borderTop == 6'd1 && borderBot == 6'd3));

  a_r9_legacy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!extMode) |-> inactStart == 9'h0C0);
endmodule

bind disp_seq_top disp_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vCount(vCount), .lineAdv(lineAdv),
  .modeWrite(modeWrite), .dispEn(dispEn), .extMode(extMode),
  .legacyMode(legacyMode), .pal50(pal50), .tallMode(tallMode),
  .seqState(seqState), .isActive(isActive), .inactStart(inactStart),
  .borderTop(borderTop), .borderBot(borderBot)
);

// File: tb/disp_seq_top_tb_top.sv
`timescale 1ns/1ps
module disp_seq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] vCount = '0;
  logic lineAdv = 1'b0, modeWrite = 1'b0, dispEn = 1'b1;
  logic extMode = 1'b1, legacyMode = 1'b0, pal50 = 1'b0, tallMode = 1'b0;
  logic [1:0] seqState;
  logic isActive, vblankFlag;
  logic [8:0] inactStart;
  logic [5:0] borderTop, borderBot;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disp_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .vCount(vCount), .lineAdv(lineAdv),
    .modeWrite(modeWrite), .dispEn(dispEn), .extMode(extMode),
    .legacyMode(legacyMode), .pal50(pal50), .tallMode(tallMode),
    .seqState(seqState), .isActive(isActive), .vblankFlag(vblankFlag),
    .inactStart(inactStart), .borderTop(borderTop), .borderBot(borderBot)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present a new line; state is sampled at the following falling edge
  task automatic adv(input logic [8:0] v);
    @(negedge clk); vCount = v; lineAdv = 1'b1;
    @(negedge clk); lineAdv = 1'b0;
  endtask

  task automatic mwr(input logic e, input logic l);
    @(negedge clk); extMode = e; legacyMode = l; modeWrite = 1'b1;
    @(negedge clk); modeWrite = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 state", seqState, 0);
    chk("R1 isActive", isActive, 0);
    chk("R1 vblank", vblankFlag, 1);
  endtask

  task automatic t_ext_frame;
    adv(9'h1FE); chk("R3 before hidden", seqState, 0);
    adv(9'h1FF); chk("R3 prep", seqState, 1);
    chk("R7 active in prep", isActive, 1);
    adv(9'h000); chk("R3 run", seqState, 2);
    adv(9'h0DF); chk("R2 stays run", seqState, 2);
    dispEn = 1'b0; #1;
    chk("R7 disp off active", isActive, 0);
    chk("R7 disp off vblank", vblankFlag, 1);
    dispEn = 1'b1; #1;
    chk("R7 disp on vblank", vblankFlag, 0);
    adv(9'h0E0); chk("R2 to idle", seqState, 0);
    chk("R7 idle vblank", vblankFlag, 1);
  endtask

  task automatic t_legacy;
    mwr(1'b0, 1'b1); chk("R6 write high count stays idle", seqState, 0);
    adv(9'h1FF); chk("R4 hidden ignored", seqState, 0);
    adv(9'h000); chk("R4 run at zero", seqState, 2);
    adv(9'h0BF); chk("R2 legacy stays run", seqState, 2);
    adv(9'h0C0); chk("R2 legacy idle", seqState, 0);
  endtask

  task automatic t_nomode;
    adv(9'h000); chk("R4 run again", seqState, 2);
    mwr(1'b0, 1'b0); chk("R5 forced idle", seqState, 0);
    adv(9'h1FF); chk("R5 hidden stays idle", seqState, 0);
    adv(9'h000); chk("R5 zero stays idle", seqState, 0);
  endtask

  task automatic t_recover;
    adv(9'h050);
    mwr(1'b1, 1'b0); chk("R6 recover run", seqState, 2);
    mwr(1'b1, 1'b0); chk("R6 write in run ignored", seqState, 2);
    mwr(1'b0, 1'b0); chk("R5 off again", seqState, 0);
    adv(9'h1FF);
    mwr(1'b1, 1'b0); chk("R6 recover prep", seqState, 1);
    mwr(1'b1, 1'b0); chk("R6 write in prep ignored", seqState, 1);
    adv(9'h000); chk("R3 prep then run", seqState, 2);
    tallMode = 1'b1;
    adv(9'h0E0); chk("R2 tall passes E0", seqState, 2);
    adv(9'h0F0); chk("R2 tall idle at F0", seqState, 0);
  endtask

  task automatic t_params;
    for (int i = 0; i < 8; i++) begin
      logic e, p, t;
      int xs, xt, xb;
      {e, p, t} = 3'(i);
      @(negedge clk); extMode = e; legacyMode = !e; pal50 = p; tallMode = t; #1;
      if (e) begin
        xs = t ? 'hF0 : 'hE0;
        xt = t ? (p ? 24 : 1) : (p ? 38 : 11);
        xb = t ? (p ? 24 : 3) : (p ? 32 : 8);
        chk("R8 start", inactStart, xs);
        chk("R8 top", borderTop, xt);
        chk("R8 bottom", borderBot, xb);
      end else begin
        chk("R9 start", inactStart, 'hC0);
        chk("R9 top", borderTop, p ? 54 : 27);
        chk("R9 bottom", borderBot, p ? 48 : 24);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_ext_frame();
    t_legacy();
    t_nomode();
    t_recover();
    t_params();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule